// File: doc/BRIEF.md
# First-Event Run Verdict Monitor

This block watches a processor core during a bounded run and reduces everything it sees to one verdict code plus the diagnostic data behind it. It follows the retire stream, strict-decode trap pulses, memory accesses tagged with a region code, and a halt level. It also counts clock cycles against a watchdog limit. The first decisive condition ends the run: the verdict is latched, `done` rises, and every output then holds until reset.

When several conditions land on the same clock edge, a fixed priority picks the winner. From highest to lowest, the order is:

1. trap
2. unmapped access
3. halt
4. watchdog

A watchdog expiry is split further by what happened before it:

- **no-retires:** nothing ever retired.
- **entry-unreached:** instructions retired, but none at the configured entry address.
- **timeout:** the entry address was reached. The hot-PC result supplied by an external histogram is captured only with this verdict.

Top module: `run_verdict_monitor`

## Requirements
- R1: While reset is held and after its release, before any event, `done` is 0, `verdict` is 0 (running), `retire_count` is 0, `entry_reached` is 0, and all payload outputs are 0.
- R2: A `trap_valid` pulse sampled at an edge while not done sets `done` and `verdict`=1 after that edge. The same edge captures `trap_pc` and `trap_instr`. A trap outranks every other condition on the same edge.
- R3: An access with `mem_valid`=1 and `mem_region` equal to `UNMAPPED_CODE` (default 7) sets `verdict`=2 unless a trap occurs on the same edge. It captures `mem_addr` and `mem_pc`. It outranks halt and watchdog. Accesses with any other region code have no effect.
- R4: `halt`=1 sampled at an edge sets `verdict`=3 unless a trap or unmapped access occurs on the same edge. This includes the edge on which the watchdog expires.
- R5: With `wd_limit`=L, the watchdog ends the run at the (L+1)th rising edge after reset release. If the entry address was reached by then, `verdict`=4 and `hot_pc_in`/`hot_count_in` are captured. Hot outputs stay 0 for every other verdict.
- R6: A watchdog expiry after at least one retire, but with no retire at `entry_addr`, gives `verdict`=5.
- R7: A watchdog expiry with no retire at all gives `verdict`=6.
- R8: `entry_reached` becomes 1 after the first edge that samples `retire_valid`=1 with `retire_pc` equal to `entry_addr`, and stays 1.
- R9: `retire_count` counts every retire sampled up to and including the edge that sets `done`, then freezes.
- R10: Once `done` is 1, further traps, accesses, halts and retires change no output until reset.
- R11: A trap and an unmapped access on the same edge give `verdict`=1, and the unmapped payload is captured as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | 32 | PC of the retiring instruction |
| trap_valid | input | 1 | Strict-decode trap pulse |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_instr | input | 32 | Instruction word that trapped |
| mem_valid | input | 1 | Memory access this cycle |
| mem_region | input | 3 | Region code of the access |
| mem_addr | input | 32 | Effective address of the access |
| mem_pc | input | 32 | PC of the accessing instruction |
| halt | input | 1 | Core halted (level) |
| entry_addr | input | 32 | Expected entry address |
| wd_limit | input | 32 | Watchdog limit in cycles |
| hot_pc_in | input | 32 | Most frequent recent PC, from an external histogram |
| hot_count_in | input | 16 | Occurrence count of that PC |
| done | output | 1 | Run finished, outputs frozen |
| verdict | output | 3 | 0 running, 1 trap, 2 unmapped, 3 halt, 4 timeout, 5 entry unreached, 6 no retires |
| trap_pc_o | output | 32 | Captured trap PC |
| trap_instr_o | output | 32 | Captured trap instruction word |
| unmapped_addr_o | output | 32 | Captured unmapped effective address |
| unmapped_pc_o | output | 32 | Captured PC of the unmapped access |
| hot_pc_o | output | 32 | Hot PC captured on timeout |
| hot_count_o | output | 16 | Hot count captured on timeout |
| entry_reached | output | 1 | Entry address was retired |
| retire_count | output | 32 | Retires counted until done |

## Verification
The verdict logic is driven with several patterns:

- **Trap on a contested edge.** A trap arrives together with an unmapped access and a halt, which shows that priority, not arrival order, decides the verdict.
- **Mapped then unmapped accesses.** A run of mapped accesses precedes an unmapped one, which separates region decoding from mere access activity.
- **Halt before and at expiry.** A halt lands well before expiry and a second one exactly on the expiry edge, which pins the halt-over-watchdog order at the boundary.
- **Three quiet expiries.** Runs that retire at the entry, retire elsewhere, or never retire distinguish the three watchdog verdicts and check when done rises.

Traffic driven after done confirms that nothing moves once the verdict is latched.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

    typedef enum logic [2:0] {
        VERD_RUN       = 3'd0,
        VERD_TRAP      = 3'd1,
        VERD_UNMAPPED  = 3'd2,
        VERD_HALT      = 3'd3,
        VERD_TIMEOUT   = 3'd4,
        VERD_NO_ENTRY  = 3'd5,
        VERD_NO_RETIRE = 3'd6
    } verdict_e;

    // Fixed priority among conditions sampled on one edge.
    function automatic verdict_e pick_verdict(
        input logic ev_trap,
        input logic ev_unmapped,
        input logic ev_halt,
        input logic any_retire,
        input logic entry_ok
    );
        if (ev_trap)          return VERD_TRAP;
        else if (ev_unmapped) return VERD_UNMAPPED;
        else if (ev_halt)     return VERD_HALT;
        else if (!any_retire) return VERD_NO_RETIRE;
        else if (!entry_ok)   return VERD_NO_ENTRY;
        else                  return VERD_TIMEOUT;
    endfunction

endpackage

// File: rtl/rvm_capture.sv
module rvm_capture #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] data_in,
    output logic         seen,
    output logic [W-1:0] data_out
);

    typedef struct packed {
        logic         seen;
        logic [W-1:0] data;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire && !st_q.seen) begin
            st_d.seen = 1'b1;
            st_d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seen     = st_q.seen;
    assign data_out = st_q.data;

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen |=> $stable(st_q.data)); // R10

endmodule

// File: rtl/rvm_watchdog.sv
module rvm_watchdog #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        if (!freeze) cyc_d = cyc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    assign expire = !freeze && (cyc_q == limit);

    AST_WD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(cyc_q)); // R10

endmodule

// File: rtl/rvm_retire_track.sv
module rvm_retire_track #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             retire_valid,
    input  logic [XLEN-1:0]  retire_pc,
    input  logic [XLEN-1:0]  entry_addr,
    output logic             entry_hit,
    output logic             entry_seen,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] cnt;
    } trk_st_t;

    trk_st_t st_d, st_q;

    assign entry_hit = retire_valid && (retire_pc == entry_addr);

    always_comb begin
        st_d = st_q;
        if (!freeze) begin
            if (retire_valid) st_d.cnt  = st_q.cnt + 1'b1;
            if (entry_hit)    st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign entry_seen = st_q.seen;
    assign count      = st_q.cnt;

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(st_q.cnt)); // R9
    AST_ENTRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen |=> st_q.seen); // R8

endmodule

// File: rtl/run_verdict_monitor.sv
module run_verdict_monitor
    import rvm_pkg::*;
#(
    parameter int          XLEN          = 32,
    parameter int          CNT_W         = 32,
    parameter int          HOT_W         = 16,
    parameter int          REGION_W      = 3,
    parameter logic [2:0]  UNMAPPED_CODE = 3'd7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                retire_valid,
    input  logic [XLEN-1:0]     retire_pc,
    input  logic                trap_valid,
    input  logic [XLEN-1:0]     trap_pc,
    input  logic [XLEN-1:0]     trap_instr,
    input  logic                mem_valid,
    input  logic [REGION_W-1:0] mem_region,
    input  logic [XLEN-1:0]     mem_addr,
    input  logic [XLEN-1:0]     mem_pc,
    input  logic                halt,
    input  logic [XLEN-1:0]     entry_addr,
    input  logic [CNT_W-1:0]    wd_limit,
    input  logic [XLEN-1:0]     hot_pc_in,
    input  logic [HOT_W-1:0]    hot_count_in,
    output logic                done,
    output logic [2:0]          verdict,
    output logic [XLEN-1:0]     trap_pc_o,
    output logic [XLEN-1:0]     trap_instr_o,
    output logic [XLEN-1:0]     unmapped_addr_o,
    output logic [XLEN-1:0]     unmapped_pc_o,
    output logic [XLEN-1:0]     hot_pc_o,
    output logic [HOT_W-1:0]    hot_count_o,
    output logic                entry_reached,
    output logic [CNT_W-1:0]    retire_count
);

    localparam int PAIR_W = 2 * XLEN;
    localparam logic [REGION_W-1:0] UNM = REGION_W'(UNMAPPED_CODE);

    typedef struct packed {
        logic             done;
        verdict_e         verdict;
        logic [XLEN-1:0]  hot_pc;
        logic [HOT_W-1:0] hot_cnt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic ev_trap, ev_unm, wd_expire;
    logic entry_hit, entry_seen;
    logic trap_seen, unm_seen;
    logic [PAIR_W-1:0] trap_pair, unm_pair;

    assign ev_trap = trap_valid && !st_q.done;
    assign ev_unm  = mem_valid && (mem_region == UNM) && !st_q.done;

    rvm_capture #(.W(PAIR_W)) u_trap_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (ev_trap),
        .data_in  ({trap_pc, trap_instr}),
        .seen     (trap_seen),
        .data_out (trap_pair)
    );

    rvm_capture #(.W(PAIR_W)) u_unm_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (ev_unm),
        .data_in  ({mem_addr, mem_pc}),
        .seen     (unm_seen),
        .data_out (unm_pair)
    );

    rvm_watchdog #(.CNT_W(CNT_W)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (st_q.done),
        .limit  (wd_limit),
        .expire (wd_expire)
    );

    rvm_retire_track #(.XLEN(XLEN), .CNT_W(CNT_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .freeze       (st_q.done),
        .retire_valid (retire_valid),
        .retire_pc    (retire_pc),
        .entry_addr   (entry_addr),
        .entry_hit    (entry_hit),
        .entry_seen   (entry_seen),
        .count        (retire_count)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.done && (ev_trap || ev_unm || halt || wd_expire)) begin
            st_d.done    = 1'b1;
            st_d.verdict = pick_verdict(ev_trap, ev_unm, halt,
                                        (retire_count != '0) || retire_valid,
                                        entry_seen || entry_hit);
            if (st_d.verdict == VERD_TIMEOUT) begin
                st_d.hot_pc  = hot_pc_in;
                st_d.hot_cnt = hot_count_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{done: 1'b0, verdict: VERD_RUN, hot_pc: '0, hot_cnt: '0};
        else        st_q <= st_d;
    end

    assign done            = st_q.done;
    assign verdict         = st_q.verdict;
    assign {trap_pc_o, trap_instr_o}       = trap_pair;
    assign {unmapped_addr_o, unmapped_pc_o} = unm_pair;
    assign hot_pc_o        = st_q.hot_pc;
    assign hot_count_o     = st_q.hot_cnt;
    assign entry_reached   = entry_seen;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done); // R10
    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> $stable(st_q.verdict)); // R10
    AST_RUNNING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> (st_q.verdict == VERD_RUN)); // R1
    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.done && trap_valid) |=> (st_q.verdict == VERD_TRAP && trap_seen)); // R2
    AST_UNMAPPED_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.done && !trap_valid && mem_valid && mem_region == UNM)
        |=> (st_q.verdict == VERD_UNMAPPED && unm_seen)); // R3
    AST_HALT_OVER_WD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.done && halt && !trap_valid && !(mem_valid && mem_region == UNM))
        |=> (st_q.verdict == VERD_HALT)); // R4
    AST_HOT_ONLY_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.verdict != VERD_TIMEOUT) |-> (st_q.hot_pc == '0 && st_q.hot_cnt == '0)); // R5

endmodule

// File: tb/run_verdict_monitor_tb_top.sv
`timescale 1ns/1ps
module run_verdict_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        retire_valid;
    logic [31:0] retire_pc;
    logic        trap_valid;
    logic [31:0] trap_pc, trap_instr;
    logic        mem_valid;
    logic [2:0]  mem_region;
    logic [31:0] mem_addr, mem_pc;
    logic        halt;
    logic [31:0] entry_addr, wd_limit, hot_pc_in;
    logic [15:0] hot_count_in;
    logic        done;
    logic [2:0]  verdict;
    logic [31:0] trap_pc_o, trap_instr_o, unmapped_addr_o, unmapped_pc_o, hot_pc_o;
    logic [15:0] hot_count_o;
    logic        entry_reached;
    logic [31:0] retire_count;

    always #2 clk = ~clk;

    run_verdict_monitor dut_i (
        .clk(clk), .rst_n(rst_n),
        .retire_valid(retire_valid), .retire_pc(retire_pc),
        .trap_valid(trap_valid), .trap_pc(trap_pc), .trap_instr(trap_instr),
        .mem_valid(mem_valid), .mem_region(mem_region), .mem_addr(mem_addr), .mem_pc(mem_pc),
        .halt(halt), .entry_addr(entry_addr), .wd_limit(wd_limit),
        .hot_pc_in(hot_pc_in), .hot_count_in(hot_count_in),
        .done(done), .verdict(verdict),
        .trap_pc_o(trap_pc_o), .trap_instr_o(trap_instr_o),
        .unmapped_addr_o(unmapped_addr_o), .unmapped_pc_o(unmapped_pc_o),
        .hot_pc_o(hot_pc_o), .hot_count_o(hot_count_o),
        .entry_reached(entry_reached), .retire_count(retire_count)
    );

    typedef struct {
        string       req;
        logic [31:0] v, tpc, tins, uaddr, upc, hpc, hcnt, rcnt, entry;
        int          cyc;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc;
    logic got;
    bit   finished = 0;

    localparam logic [31:0] ENTRY = 32'h8010_0008;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Monitor: pops one expected item when done first appears.
    always @(negedge clk) begin
        if (!rst_n) got = 1'b0;
        else if (done && !got) begin
            got = 1'b1;
            if (sb_q.size() == 0) chk("R10", "unexpected done", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, "verdict",    {29'd0, verdict}, e.v);
                chk(e.req, "trap_pc",    trap_pc_o,        e.tpc);
                chk(e.req, "trap_instr", trap_instr_o,     e.tins);
                chk(e.req, "unm_addr",   unmapped_addr_o,  e.uaddr);
                chk(e.req, "unm_pc",     unmapped_pc_o,    e.upc);
                chk(e.req, "hot_pc",     hot_pc_o,         e.hpc);
                chk(e.req, "hot_cnt",    {16'd0, hot_count_o}, e.hcnt);
                chk(e.req, "retire_cnt", retire_count,     e.rcnt);
                chk(e.req, "entry",      {31'd0, entry_reached}, e.entry);
                chk(e.req, "done_cycle", cyc,              e.cyc);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic clear_in();
        retire_valid = 0; retire_pc = 0; trap_valid = 0; trap_pc = 0; trap_instr = 0;
        mem_valid = 0; mem_region = 0; mem_addr = 0; mem_pc = 0; halt = 0;
    endtask

    task automatic do_reset(input logic [31:0] lim);
        rst_n = 0; clear_in(); wd_limit = lim;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic push(input string req, input logic [31:0] v, tpc, tins, uaddr, upc,
                        hpc, hcnt, rcnt, entry, input int c);
        exp_t e;
        e.req = req; e.v = v; e.tpc = tpc; e.tins = tins; e.uaddr = uaddr; e.upc = upc;
        e.hpc = hpc; e.hcnt = hcnt; e.rcnt = rcnt; e.entry = entry; e.cyc = c;
        sb_q.push_back(e);
    endtask

    task automatic wait_got(input string req);
        for (int i = 0; i < 300 && !got; i++) tick();
        if (!got) chk(req, "done never seen", 32'd0, 32'd1);
        clear_in();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hang expected=finish");
        finish_run();
    end

    initial begin
        entry_addr = ENTRY; hot_pc_in = 32'h8010_0010; hot_count_in = 16'd128;
        rst_n = 0; clear_in(); wd_limit = 1000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "done",    {31'd0, done}, 0);
        chk("R1", "verdict", {29'd0, verdict}, 0);
        chk("R1", "count",   retire_count, 0);
        chk("R1", "entry",   {31'd0, entry_reached}, 0);
        chk("R1", "trap_pc", trap_pc_o, 0);
        chk("R1", "hot_pc",  hot_pc_o, 0);

        // R2/R11: trap with unmapped access and halt on the same edge
        do_reset(1000);
        push("R2 R11", 1, 32'h8010_0040, 32'hDEAD_0001, 32'h1000_2000, 32'h8010_0044,
             0, 0, 2, 1, 3);
        retire_valid = 1; retire_pc = ENTRY; tick();
        retire_pc = ENTRY + 4; tick();
        retire_valid = 0; trap_valid = 1; trap_pc = 32'h8010_0040; trap_instr = 32'hDEAD_0001;
        mem_valid = 1; mem_region = 3'd7; mem_addr = 32'h1000_2000; mem_pc = 32'h8010_0044;
        halt = 1;
        wait_got("R2");
        // R10: activity after done changes nothing
        for (int i = 0; i < 4; i++) begin
            trap_valid = 1; trap_pc = 32'h1111_0000 + i; trap_instr = 32'h2222_0000;
            mem_valid = 1; mem_region = 3'd7; mem_addr = 32'h3333_0000; mem_pc = 32'h4444_0000;
            retire_valid = 1; retire_pc = ENTRY; halt = 1;
            tick();
        end
        @(negedge clk);
        chk("R10", "verdict",    {29'd0, verdict}, 1);
        chk("R10", "trap_pc",    trap_pc_o, 32'h8010_0040);
        chk("R10", "trap_instr", trap_instr_o, 32'hDEAD_0001);
        chk("R10", "unm_addr",   unmapped_addr_o, 32'h1000_2000);
        chk("R10", "unm_pc",     unmapped_pc_o, 32'h8010_0044);
        chk("R9",  "frozen count", retire_count, 2);
        chk("R10", "done",       {31'd0, done}, 1);

        // R3: mapped accesses ignored, then unmapped outranks halt
        do_reset(1000);
        push("R3", 2, 0, 0, 32'h1F80_0010, 32'h8010_0020, 0, 0, 0, 0, 4);
        mem_valid = 1; mem_region = 3'd2; mem_addr = 32'h0010_0000; mem_pc = ENTRY;
        repeat (3) tick();
        mem_region = 3'd7; mem_addr = 32'h1F80_0010; mem_pc = 32'h8010_0020; halt = 1;
        wait_got("R3");

        // R4/R8/R9: halt with retires, retire on the deciding edge counted
        do_reset(1000);
        push("R4", 3, 0, 0, 0, 0, 0, 0, 4, 1, 4);
        retire_valid = 1; retire_pc = ENTRY; tick();
        @(negedge clk);
        chk("R8", "entry_reached", {31'd0, entry_reached}, 1);
        chk("R9", "count after 1", retire_count, 1);
        retire_pc = ENTRY + 4; tick();
        tick();
        retire_pc = ENTRY + 8; halt = 1;
        wait_got("R4");

        // R4: halt on the exact watchdog expiry edge (L=8 -> edge 9)
        do_reset(8);
        push("R4 at expiry", 3, 0, 0, 0, 0, 0, 0, 1, 1, 9);
        retire_valid = 1; retire_pc = ENTRY; tick();
        retire_valid = 0;
        repeat (7) tick();
        halt = 1;
        wait_got("R4");

        // R5: timeout after entry reached, hot data captured
        do_reset(20);
        push("R5", 4, 0, 0, 0, 0, 32'h8010_0010, 128, 1, 1, 21);
        retire_valid = 1; retire_pc = ENTRY; tick();
        retire_valid = 0;
        wait_got("R5");

        // R6: retires elsewhere, entry never reached
        do_reset(15);
        push("R6", 5, 0, 0, 0, 0, 0, 0, 3, 0, 16);
        retire_valid = 1; retire_pc = 32'h8020_0000; repeat (3) tick();
        retire_valid = 0;
        wait_got("R6");

        // R7: nothing ever retires
        do_reset(10);
        push("R7", 6, 0, 0, 0, 0, 0, 0, 0, 0, 11);
        wait_got("R7");

        chk("R10", "scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule